// File: doc/BRIEF.md
# Host Bridge Configuration Access Router

This block sits behind the host side of a bridge that presents two logical devices on bus 0. Device 0 is the host-to-PCI bridge. Device 1 is a virtual PCI-to-PCI bridge, and the graphics port is the secondary bus behind it. Each configuration request carries a bus number, a device number, a dword register index, byte enables and write data. The block decides where the request goes: to the local register set of device 0, to the local register set of device 1, to the primary PCI bus, or to the secondary bus. For forwarded requests it also decides whether the cycle is Type 0 or Type 1.

The routing decision uses the virtual bridge's bus-number register, following the normal rules of a PCI-to-PCI bridge. A disable bit held in device 0 can hide device 1. While device 1 is hidden, every access to it is aborted. The abort returns all ones, changes no register, and sets a sticky master-abort flag that belongs to device 0. Every request is answered exactly one cycle after it is accepted.

Top module: `cfg_access_router`

## Requirements
- R1: A request accepted while `req_valid` is high gets `rsp_valid` high on the next cycle only. `rsp_rdata` is 0 for writes and for forwarded requests, except where R7 applies.
- R2: A request whose bus equals the primary bus number is handled as follows. Device 0 goes to the host bridge registers, with route code 0. Device 1, while enabled, goes to the bridge registers, with route code 0. Any other device goes to the primary bus as Type 0, with route code 1. A local read returns the addressed dword.
- R3: A request whose bus equals the secondary bus number is forwarded to the secondary bus as Type 0, with route code 2 and `rsp_type1` low.
- R4: A request whose bus is above the secondary number and no higher than the subordinate number is forwarded to the secondary bus as Type 1, with route code 2 and `rsp_type1` high.
- R5: A request whose bus is neither the primary bus nor inside the secondary-to-subordinate range goes to the primary bus as Type 1, with route code 1.
- R6: Bit 1 of device 0 dword 20 is the device 1 disable bit. While it is 1, every access to device 1 on the primary bus is aborted with route code 3.
- R7: An aborted access returns all ones in `rsp_rdata`.
- R8: An aborted write changes no register.
- R9: An aborted access sets `master_abort`. The flag also reads back as bit 29 of device 0 dword 1, whose low 16 bits are stored.
- R10: `master_abort` stays set until a write to device 0 dword 1 has byte enable 3 set and data bit 29 equal to 1.
- R11: A local write updates only the byte lanes whose enable bit is set.
- R12: Device 1 dword 6 holds the primary bus number in byte 0, the secondary in byte 1 and the subordinate in byte 2. All three reset to 0. A write to this dword takes effect for the very next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_reg | input | 6 | Dword register index |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_route | output | 2 | 0 local, 1 primary bus, 2 secondary bus, 3 aborted |
| rsp_type1 | output | 1 | Forwarded cycle is Type 1 |
| rsp_rdata | output | 32 | Read data |
| master_abort | output | 1 | Sticky master-abort flag of device 0 |

## Verification
Two things meet in a single cycle. One is a register write that changes routing state: the disable bit or a bus-number byte. The other is the decode of the request that follows it immediately. The bench issues such pairs one after the other, so the second request is decoded against the value that was just committed, and it compares the route, type and data with a model that applies the write first. The same pressure is put on the sticky flag: an abort is followed straight away by clearing writes, some of which miss the flag's byte lane or its bit, and the flag is checked after each one.

// File: rtl/cfg_access_router.sv
module cfg_access_router #(
  parameter int DEV_W      = 5,
  parameter int REG_W      = 6,
  parameter int PM_REG     = 20,
  parameter int DIS_BIT    = 1,
  parameter int STAT_REG   = 1,
  parameter int MA_BIT     = 29,
  parameter int BUSNUM_REG = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [7:0]       req_bus,
  input  logic [DEV_W-1:0] req_dev,
  input  logic [REG_W-1:0] req_reg,
  input  logic [3:0]       req_be,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  output logic [1:0]       rsp_route,
  output logic             rsp_type1,
  output logic [31:0]      rsp_rdata,
  output logic             master_abort
);
  localparam int NREG = 1 << REG_W;
  localparam logic [1:0] RT_LOCAL = 2'd0, RT_PRI = 2'd1, RT_SEC = 2'd2, RT_ABORT = 2'd3;

  logic [31:0] d0_regs [NREG];
  logic [31:0] d1_regs [NREG];

  wire [7:0] pri_bus = d1_regs[BUSNUM_REG][7:0];
  wire [7:0] sec_bus = d1_regs[BUSNUM_REG][15:8];
  wire [7:0] sub_bus = d1_regs[BUSNUM_REG][23:16];
  wire dev1_off = d0_regs[PM_REG][DIS_BIT];

  wire on_pri   = req_bus == pri_bus;
  wire hit_d0   = on_pri && req_dev == DEV_W'(0);
  wire hit_d1   = on_pri && req_dev == DEV_W'(1);
  wire hidden   = hit_d1 && dev1_off;
  wire loc_d1   = hit_d1 && !dev1_off;
  wire to_sec0  = !on_pri && req_bus == sec_bus;
  wire to_sec1  = !on_pri && req_bus > sec_bus && req_bus <= sub_bus;
  wire [31:0] be_mask = {{8{req_be[3]}}, {8{req_be[2]}}, {8{req_be[1]}}, {8{req_be[0]}}};
  wire clr_ma = req_valid && req_write && hit_d0 && req_reg == REG_W'(STAT_REG)
                && req_be[MA_BIT/8] && req_wdata[MA_BIT];

  logic [1:0]  nxt_route;
  logic        nxt_type1;
  logic [31:0] nxt_rdata;

  always_comb begin
    nxt_route = RT_PRI;
    nxt_type1 = 1'b1;
    nxt_rdata = '0;
    if (hidden) begin
      nxt_route = RT_ABORT;
      nxt_type1 = 1'b0;
      nxt_rdata = '1;
    end else if (hit_d0 || loc_d1) begin
      nxt_route = RT_LOCAL;
      nxt_type1 = 1'b0;
      if (!req_write) begin
        if (hit_d0 && req_reg == REG_W'(STAT_REG))
          nxt_rdata = (d0_regs[STAT_REG] & 32'h0000_ffff) | (32'(master_abort) << MA_BIT);
        else if (hit_d0)
          nxt_rdata = d0_regs[req_reg];
        else
          nxt_rdata = d1_regs[req_reg];
      end
    end else if (on_pri) begin
      nxt_type1 = 1'b0;
    end else if (to_sec0) begin
      nxt_route = RT_SEC;
      nxt_type1 = 1'b0;
    end else if (to_sec1) begin
      nxt_route = RT_SEC;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        d0_regs[i] <= '0;
        d1_regs[i] <= '0;
      end
      rsp_valid    <= 1'b0;
      rsp_route    <= RT_LOCAL;
      rsp_type1    <= 1'b0;
      rsp_rdata    <= '0;
      master_abort <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_route <= nxt_route;
        rsp_type1 <= nxt_type1;
        rsp_rdata <= nxt_rdata;
        if (req_write && hit_d0)
          d0_regs[req_reg] <= (d0_regs[req_reg] & ~be_mask) | (req_wdata & be_mask);
        if (req_write && loc_d1)
          d1_regs[req_reg] <= (d1_regs[req_reg] & ~be_mask) | (req_wdata & be_mask);
      end
      if (req_valid && hidden) master_abort <= 1'b1;
      else if (clr_ma)         master_abort <= 1'b0;
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);  // R1
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);  // R1
  AST_LOCAL_NOT_TYPE1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_route == RT_LOCAL |-> !rsp_type1);  // R2
  AST_ABORT_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_route == RT_ABORT |-> rsp_rdata == 32'hffff_ffff);  // R7
  AST_ABORT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_route == RT_ABORT |-> master_abort);  // R9
  AST_MA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    master_abort && !clr_ma |=> master_abort);  // R10
  AST_HIDDEN_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && hidden |=> $stable(d1_regs[BUSNUM_REG]));  // R8
endmodule

// File: tb/cfg_access_router_tb_top.sv
module cfg_access_router_tb_top;
  logic clk = 0;
  always #2 clk = ~clk;

  logic rst_n, req_valid, req_write;
  logic [7:0] req_bus;
  logic [4:0] req_dev;
  logic [5:0] req_reg;
  logic [3:0] req_be;
  logic [31:0] req_wdata;
  logic rsp_valid, rsp_type1, master_abort;
  logic [1:0] rsp_route;
  logic [31:0] rsp_rdata;

  cfg_access_router dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_bus(req_bus), .req_dev(req_dev), .req_reg(req_reg), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_route(rsp_route),
    .rsp_type1(rsp_type1), .rsp_rdata(rsp_rdata), .master_abort(master_abort));

  int total = 0, bad = 0;
  logic [31:0] m0 [64];
  logic [31:0] m1 [64];
  logic m_ma;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic req(bit wr, int bus, int dev, int rg, bit [3:0] be, bit [31:0] wd, string note);
    logic [7:0] pri, sec, sub;
    logic [1:0] e_route;
    logic e_t1;
    logic [31:0] e_rd, mask;
    string tag;
    bit off;
    pri = m1[6][7:0]; sec = m1[6][15:8]; sub = m1[6][23:16];
    off = m0[20][1];
    mask = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    e_rd = 0; e_t1 = 0;
    if (bus == pri) begin
      if (dev == 0) begin
        e_route = 0; tag = "R2";
        if (!wr) e_rd = (rg == 1) ? ((m0[1] & 32'h0000ffff) | (32'(m_ma) << 29)) : m0[rg];
        if (wr) m0[rg] = (m0[rg] & ~mask) | (wd & mask);
        if (wr && rg == 1 && be[3] && wd[29]) m_ma = 0;
      end else if (dev == 1 && off) begin
        e_route = 3; tag = "R6/R7"; e_rd = 32'hffffffff; m_ma = 1;
      end else if (dev == 1) begin
        e_route = 0; tag = "R2";
        if (!wr) e_rd = m1[rg];
        if (wr) m1[rg] = (m1[rg] & ~mask) | (wd & mask);
      end else begin
        e_route = 1; tag = "R2";
      end
    end else if (bus == sec) begin
      e_route = 2; tag = "R3";
    end else if (bus > sec && bus <= sub) begin
      e_route = 2; e_t1 = 1; tag = "R4";
    end else begin
      e_route = 1; e_t1 = 1; tag = "R5";
    end
    req_valid = 1; req_write = wr; req_bus = 8'(bus); req_dev = 5'(dev);
    req_reg = 6'(rg); req_be = be; req_wdata = wd;
    @(posedge clk); @(negedge clk);
    chk("R1", {note, " rsp_valid"}, 32'(rsp_valid), 1);
    chk(tag, {note, " route"}, 32'(rsp_route), 32'(e_route));
    chk(tag, {note, " type1"}, 32'(rsp_type1), 32'(e_t1));
    chk({tag, "/R1"}, {note, " rdata"}, rsp_rdata, e_rd);
    chk("R9/R10", {note, " master_abort"}, 32'(master_abort), 32'(m_ma));
    req_valid = 0;
    @(negedge clk);
    chk("R1", {note, " idle"}, 32'(rsp_valid), 0);
  endtask

  task automatic req_b2b(int bus, bit [31:0] wd, string note);
    // R12: a bus-number write immediately followed by a request decoded against it
    req_valid = 1; req_write = 1; req_bus = 0; req_dev = 1; req_reg = 6; req_be = 4'b0111; req_wdata = wd;
    m1[6] = (m1[6] & 32'hff000000) | (wd & 32'h00ffffff);
    @(negedge clk);
    req_write = 0; req_bus = 8'(bus); req_dev = 0; req_reg = 0;
    @(negedge clk);
    req_valid = 0;
    chk("R12", {note, " route"}, 32'(rsp_route), (bus == 0) ? 0 : 2);
    chk("R12", {note, " type1"}, 32'(rsp_type1), (bus > int'(wd[15:8])) ? 1 : 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin m0[i] = 0; m1[i] = 0; end
    m_ma = 0;
    rst_n = 0; req_valid = 0; req_write = 0; req_bus = 0; req_dev = 0;
    req_reg = 0; req_be = 0; req_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "reset rsp_valid", 32'(rsp_valid), 0);
    chk("R9", "reset master_abort", 32'(master_abort), 0);
    req(0, 0, 0, 20, 4'hf, 0, "R2 reset pm read");
    req(1, 0, 1, 6, 4'b0111, 32'hAA050200, "R12 bus numbers");
    req(0, 0, 1, 6, 4'hf, 0, "R12 readback");
    req(0, 2, 0, 0, 4'hf, 0, "R3 secondary");
    req(1, 3, 4, 7, 4'hf, 32'h1234, "R4 low");
    req(0, 5, 9, 1, 4'hf, 0, "R4 top");
    req(0, 6, 0, 0, 4'hf, 0, "R5 above sub");
    req(0, 1, 0, 0, 4'hf, 0, "R5 below sec");
    req(0, 0, 3, 0, 4'hf, 0, "R2 other dev");
    req(1, 0, 0, 10, 4'b0101, 32'hffffffff, "R11 be write");
    req(0, 0, 0, 10, 4'hf, 0, "R11 readback");
    req(1, 0, 0, 20, 4'b0001, 32'h2, "R6 disable");
    req(0, 0, 1, 6, 4'hf, 0, "R6 R7 hidden read");
    req(1, 0, 1, 6, 4'hf, 32'h0, "R8 hidden write");
    req(0, 0, 0, 1, 4'hf, 0, "R9 status read");
    req(1, 0, 0, 1, 4'hf, 32'h0000_1234, "R10 write zero");
    req(1, 0, 0, 1, 4'b0111, 32'h2000_0000, "R10 wrong lane");
    req(0, 0, 0, 1, 4'hf, 0, "R10 still set");
    req(1, 0, 0, 1, 4'b1000, 32'h2000_0000, "R10 clear");
    req(0, 0, 0, 1, 4'hf, 0, "R10 cleared");
    req(1, 0, 0, 20, 4'b0001, 32'h0, "R6 enable");
    req(0, 0, 1, 6, 4'hf, 0, "R8 unchanged");
    req(0, 4, 0, 0, 4'hf, 0, "R4 still");
    req_b2b(7, 32'h000A0700, "R12 b2b sec7");
    req_b2b(9, 32'h000A0700, "R12 b2b inside");
    req(0, 11, 0, 0, 4'hf, 0, "R5 beyond");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule